// File: doc/BRIEF.md
# Interleaved Memory Block-Fill Controller

This block serves cache-line fills from a set of low-order-interleaved memory banks. A requester presents a word address through a valid/ready request channel. The controller rounds the address down to the block boundary and spends one cycle sending the block's row to every bank. The banks then look up their words in parallel during one fixed access latency. After that, the controller streams the words back one per cycle on a valid/ready response channel and raises a one-cycle done pulse after the final beat.

A block holds one word from each bank, so its size equals the bank count. Word address A is stored in bank A mod M, at row A div M. M is a power of two, so the bank is the low address bits and the row is the remaining high bits. A plain write port preloads the banks.

A parameter selects a non-interleaved mode for comparison. In that mode each word goes through its own address, access and transfer phases, one after another.

Back-pressure rules:
- Request channel: a request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle.
- Response channel: a beat completes on a cycle where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the current beat's data and flags stay unchanged and the controller does not advance.

Top module: `ilv_fill_ctrl`

## Requirements
- R1: The write port stores `wr_data` for word address A in bank A mod M, row A div M. A later fill of the block containing A returns that value on beat A mod M.
- R2: A request address that is not block-aligned is rounded down: the fill returns words from (address with its low log2(M) bits cleared) upward.
- R3: In interleaved mode with `rsp_ready` held high, beat k completes on the clock edge 2 + LAT + k edges after the accepting edge. With M=4 and LAT=6 the last beat completes 11 edges after acceptance.
- R4: Beats carry consecutive word addresses in increasing order. `rsp_last` is high on the final beat only.
- R5: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_last` hold their values, and no beat is skipped.
- R6: `busy` is high and `req_ready` is low from the cycle after acceptance until the last beat completes. A request presented in that window is ignored and starts no later fill.
- R7: `fill_done` is high for exactly one cycle: the cycle after the last beat completes, during which `busy` is already low.
- R8: With INTERLEAVED=0, beat k completes 8(k+1) edges after acceptance when LAT=6, which is 32 edges for four words. Only one bank is accessed at a time.
- R9: After reset, `req_ready` is 1 and `busy`, `rsp_valid` and `fill_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the block (low bits ignored) |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Requester takes the beat |
| rsp_data | output | WORD_W | Word of the current beat |
| rsp_last | output | 1 | Current beat is the final word of the block |
| fill_done | output | 1 | One-cycle pulse after the last beat |
| busy | output | 1 | Fill in progress |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | ADDR_W | Preload word address |
| wr_data | input | WORD_W | Preload data |

## Verification
The bench builds two instances, each with four 32-bit banks of 16 rows and a 6-cycle access latency. One instance is interleaved and the other is not. This lets the 11-edge fill and the 32-edge serial fill be measured against each other on the same preload data. Using four banks and a 64-word space allows misaligned requests at every block offset, including the top block. A stalled response channel and a request arriving during a fill can be exercised within a few dozen cycles.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACCESS,
    ST_XFER
  } fill_state_e;
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16,
  parameter int ROW_W  = 4,
  parameter int LAT    = 6,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_start,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_finishing
);
  logic [WORD_W-1:0] store [DEPTH];
  logic [CNT_W-1:0]  lat_cnt;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_row] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_start) rd_data <= store[rd_row];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else if (rd_start) lat_cnt <= CNT_W'(LAT);
    else if (lat_cnt != '0) lat_cnt <= lat_cnt - 1'b1;
  end

  assign rd_finishing = (lat_cnt == CNT_W'(1));

  // R3: an access is only launched on an idle bank
  assert_start_on_idle_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |-> (lat_cnt == '0));
endmodule

// File: rtl/ilv_beat_seq.sv
module ilv_beat_seq
  import ilv_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int BANK_W      = 2,
  parameter int INTERLEAVED = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 rsp_ready,
  input  logic                 access_done,
  output logic [NUM_BANKS-1:0] bank_start,
  output logic [BANK_W-1:0]    beat,
  output logic                 rsp_valid,
  output logic                 rsp_last,
  output logic                 fill_done,
  output logic                 busy
);
  localparam logic [BANK_W-1:0] LAST_BEAT = BANK_W'(NUM_BANKS - 1);

  fill_state_e state_q;
  logic        handshake;

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign rsp_valid = (state_q == ST_XFER);
  assign rsp_last  = rsp_valid && (beat == LAST_BEAT);
  assign handshake = rsp_valid && rsp_ready;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_start
    assign bank_start[i] = (state_q == ST_ADDR) &&
                           ((INTERLEAVED != 0) || (beat == BANK_W'(i)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      beat      <= '0;
      fill_done <= 1'b0;
    end else begin
      fill_done <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          state_q <= ST_ADDR;
          beat    <= '0;
        end
        ST_ADDR:   state_q <= ST_ACCESS;
        ST_ACCESS: if (access_done) state_q <= ST_XFER;
        ST_XFER: if (handshake) begin
          if (beat == LAST_BEAT) begin
            state_q   <= ST_IDLE;
            fill_done <= 1'b1;
          end else begin
            beat    <= beat + 1'b1;
            state_q <= (INTERLEAVED != 0) ? ST_XFER : ST_ADDR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  assert_hold_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(beat)));

  assert_beat_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && !rsp_last) |=> (beat == BANK_W'($past(beat) + 1'b1)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (handshake && rsp_last) |=> (fill_done && !busy));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);

  if (INTERLEAVED == 0) begin : g_serial_chk
    assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_start));
  end
endmodule

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl #(
  parameter int WORD_W      = 32,
  parameter int NUM_BANKS   = 4,
  parameter int BANK_DEPTH  = 16,
  parameter int ACCESS_LAT  = 6,
  parameter int INTERLEAVED = 1,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int ROW_W      = $clog2(BANK_DEPTH),
  localparam int ADDR_W     = BANK_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_last,
  output logic              fill_done,
  output logic              busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(ACCESS_LAT + 1);

  logic [ROW_W-1:0]     base_row;
  logic [NUM_BANKS-1:0] bank_start;
  logic [NUM_BANKS-1:0] bank_fin;
  logic [WORD_W-1:0]    bank_rdata [NUM_BANKS];
  logic [BANK_W-1:0]    beat;
  logic                 access_done;

  // Block-aligned row: the low bank-select bits are dropped
  always_ff @(posedge clk) begin
    if (!rst_n) base_row <= '0;
    else if (req_valid && req_ready) base_row <= req_addr[ADDR_W-1:BANK_W];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ilv_bank #(
      .WORD_W(WORD_W), .DEPTH(BANK_DEPTH), .ROW_W(ROW_W),
      .LAT(ACCESS_LAT), .CNT_W(CNT_W)
    ) bank_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en && (wr_addr[BANK_W-1:0] == BANK_W'(b))),
      .wr_row       (wr_addr[ADDR_W-1:BANK_W]),
      .wr_data      (wr_data),
      .rd_start     (bank_start[b]),
      .rd_row       (base_row),
      .rd_data      (bank_rdata[b]),
      .rd_finishing (bank_fin[b])
    );
  end

  if (INTERLEAVED != 0) begin : g_par_done
    assign access_done = &bank_fin;
  end else begin : g_ser_done
    assign access_done = bank_fin[beat];
  end

  ilv_beat_seq #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .INTERLEAVED(INTERLEAVED)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_ready   (rsp_ready),
    .access_done (access_done),
    .bank_start  (bank_start),
    .beat        (beat),
    .rsp_valid   (rsp_valid),
    .rsp_last    (rsp_last),
    .fill_done   (fill_done),
    .busy        (busy)
  );

  assign rsp_data = bank_rdata[beat];

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> ($stable(rsp_data) && $stable(rsp_last)));

  assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

// File: tb/ilv_fill_ctrl_tb_top.sv
module ilv_fill_ctrl_tb_top;
  localparam int WORD_W = 32;
  localparam int NB     = 4;
  localparam int ADDR_W = 6;
  localparam int NWORDS = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid_a, req_valid_b, rsp_ready, wr_en;
  logic [ADDR_W-1:0] req_addr, wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic req_ready_a, rsp_valid_a, rsp_last_a, fill_done_a, busy_a;
  logic req_ready_b, rsp_valid_b, rsp_last_b, fill_done_b, busy_b;
  logic [WORD_W-1:0] rsp_data_a, rsp_data_b;
  logic [WORD_W-1:0] model [NWORDS];

  int checks = 0;
  int fails  = 0;

  ilv_fill_ctrl #(.INTERLEAVED(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid_a), .req_ready(req_ready_a),
    .req_addr(req_addr), .rsp_valid(rsp_valid_a), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data_a), .rsp_last(rsp_last_a), .fill_done(fill_done_a),
    .busy(busy_a), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  ilv_fill_ctrl #(.INTERLEAVED(0)) dut_seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid_b), .req_ready(req_ready_b),
    .req_addr(req_addr), .rsp_valid(rsp_valid_b), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data_b), .rsp_last(rsp_last_b), .fill_done(fill_done_b),
    .busy(busy_b), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  // {request address, expected aligned base}
  localparam logic [11:0] VEC [0:5] = '{
    {6'd0,  6'd0},  {6'd5,  6'd4},  {6'd14, 6'd12},
    {6'd63, 6'd60}, {6'd32, 6'd32}, {6'd27, 6'd24}
  };

  function automatic logic [WORD_W-1:0] word_of(input int a);
    return 32'h5A00_0000 + a * 32'h0001_0103;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  // first/step: edge (after acceptance) on which beat k completes = first + step*k
  task automatic run_fill(input int which, input logic [ADDR_W-1:0] addr,
                          input int base, input int first, input int step, input string ttag);
    int beats = 0;
    int n = 0;
    logic v, l, bz, dn, rr;
    logic [WORD_W-1:0] d;
    @(negedge clk);
    rr = which ? req_ready_b : req_ready_a;
    check("R6 ready before request", rr, 1);
    req_addr = addr;
    if (which) req_valid_b = 1'b1; else req_valid_a = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_a = 1'b0; req_valid_b = 1'b0;
    while (beats < NB && n < 100) begin
      v  = which ? rsp_valid_b : rsp_valid_a;
      d  = which ? rsp_data_b  : rsp_data_a;
      l  = which ? rsp_last_b  : rsp_last_a;
      bz = which ? busy_b      : busy_a;
      check("R6 busy during fill", bz, 1);
      if (v) begin
        check("R1 R2 R4 beat data", d, model[base + beats]);
        check("R4 last flag", l, (beats == NB - 1));
        check(ttag, n + 1, first + step * beats);
        beats++;
      end
      @(negedge clk);
      n++;
    end
    check("R7 done pulse", which ? fill_done_b : fill_done_a, 1);
    check("R7 busy low with done", which ? busy_b : busy_a, 0);
    @(negedge clk);
    check("R7 done one cycle", which ? fill_done_b : fill_done_a, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid_a = 1'b0; req_valid_b = 1'b0; rsp_ready = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset req_ready", req_ready_a, 1);
    check("R9 reset busy", busy_a, 0);
    check("R9 reset rsp_valid", rsp_valid_a, 0);
    check("R9 reset fill_done", fill_done_a, 0);
    check("R9 reset seq req_ready", req_ready_b, 1);
    rst_n = 1'b1;

    for (int a = 0; a < NWORDS; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = word_of(a); model[a] = word_of(a);
    end
    @(negedge clk);
    wr_en = 1'b0;
    rsp_ready = 1'b1;

    // R2 R3 R4 table walk on the interleaved instance
    for (int i = 0; i < 6; i++)
      run_fill(0, VEC[i][11:6], int'(VEC[i][5:0]), 8, 1, "R3 beat timing");

    // R8 non-interleaved timing
    run_fill(1, 6'd20, 20, 8, 8, "R8 serial beat timing");
    run_fill(1, 6'd43, 40, 8, 8, "R8 serial beat timing");

    // R1 rewrite a word through the write port, then fill its block
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 6'd49; wr_data = 32'hDEAD_BEEF; model[49] = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_en = 1'b0;
    run_fill(0, 6'd49, 48, 8, 1, "R1 R3 beat timing after rewrite");

    // R5 R6 back-pressure and request while busy
    begin
      int beats = 0;
      int n = 0;
      rsp_ready = 1'b0;
      @(negedge clk);
      req_addr = 6'd8; req_valid_a = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid_a = 1'b0;
      while (!rsp_valid_a && n < 30) begin @(negedge clk); n++; end
      check("R3 first beat after stall start", n, 7);
      for (int s = 0; s < 3; s++) begin
        check("R5 valid held", rsp_valid_a, 1);
        check("R5 data held", rsp_data_a, model[8]);
        check("R5 last held low", rsp_last_a, 0);
        check("R6 ready low while busy", req_ready_a, 0);
        if (s == 1) begin req_addr = 6'd44; req_valid_a = 1'b1; end
        else req_valid_a = 1'b0;
        @(negedge clk);
      end
      req_valid_a = 1'b0;
      rsp_ready = 1'b1;
      n = 0;
      while (beats < NB && n < 20) begin
        if (rsp_valid_a) begin
          check("R5 R6 data after stall", rsp_data_a, model[8 + beats]);
          beats++;
        end
        @(negedge clk);
        n++;
      end
      check("R5 all beats delivered", beats, NB);
      check("R7 done after stalled fill", fill_done_a, 1);
      for (int s = 0; s < 12; s++) begin
        check("R6 ignored request starts nothing", {busy_a, rsp_valid_a}, 2'b00);
        @(negedge clk);
      end
    end

    report();
  end
endmodule